// File: doc/BRIEF.md
# Configuration Health State Tracker

This block keeps a health record for a fixed set of interchangeable half-configuration slots, 20 by default. On each cycle an outside scheduler may report that a left slot and a right slot ran together, and whether their outputs agreed. This is a temporal vote between two competitors rather than a spatial majority. The tracker counts agreements and disagreements for each slot over an evaluation window. It then moves the slot through a four-state lifecycle that decides whether the slot is trusted, doubted, out of service or freshly repaired.

When a slot's disagreements exceed a programmable limit inside its window, the slot is taken out of service. A single repair request is then raised toward an outside regeneration agent. When the agent acknowledges, the slot goes back into service at once as refurbished. It becomes fully trusted again only after it completes a window with few enough disagreements. Both thresholds are set as integer disagreement counts per window, so no division is needed. Any single slot's state and counters can be read through an index port.

Top module: `hst_top`

## Requirements
- R1: After reset every slot reads state 0 with zero disagreement and agreement counts, `repReq` is low and `cmpErr` is low.
- R2: `rdState`, `rdDisc` and `rdCorr` show the state and counts of slot `rdIdx` from the cycle after the strobe that changed them. The state codes are 0 pristine, 1 suspect, 2 under repair and 3 refurbished. An index of `NUM_SLOTS` or more reads as 0.
- R3: A valid strobe with `agree`=1 adds one to the agreement count of both named slots. With `agree`=0 it adds one to the disagreement count of both.
- R4: A pristine slot named in a disagreeing strobe becomes suspect.
- R5: A suspect or refurbished slot whose updated disagreement count exceeds `repairMaxDisc` becomes under repair.
- R6: `repReq` is high while any slot waits for repair, and `repSlot` names the lowest-index waiting slot. The request stays up until `repAck`. Each entry into under repair gives exactly one handshake, and further strobes on an under-repair slot change neither its state nor the request.
- R7: `repAck` while `repReq` is high moves slot `repSlot` to refurbished and clears its counts in the next cycle.
- R8: When a slot's disagreement plus agreement count reaches `WIN_LEN`, both counts return to zero and a new window begins.
- R9: A refurbished slot whose window completes with a disagreement count of at most `operMaxDisc` becomes pristine.
- R10: A strobe that names the same slot twice, or any index of `NUM_SLOTS` or more, changes no slot, and `cmpErr` is high in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Compare result strobe |
| leftIdx | input | IDX_W | Left slot of the pair |
| rightIdx | input | IDX_W | Right slot of the pair |
| agree | input | 1 | 1 when the two outputs matched |
| repairMaxDisc | input | CNT_W | Largest disagreement count tolerated before repair |
| operMaxDisc | input | CNT_W | Largest disagreement count allowing return to pristine |
| rdIdx | input | IDX_W | Slot selected for readout |
| rdState | output | 2 | Health state of the selected slot |
| rdDisc | output | CNT_W | Disagreement count of the selected slot |
| rdCorr | output | CNT_W | Agreement count of the selected slot |
| cmpErr | output | 1 | Previous strobe was rejected |
| repReq | output | 1 | A slot waits for regeneration |
| repSlot | output | IDX_W | Slot to regenerate |
| repAck | input | 1 | Regeneration of `repSlot` is done |

## Verification
The bench drives a slot pair to exactly one disagreement past the repair limit. A design with an off-by-one in the limit would move to under repair one strobe early or late. Two slots wait for repair at the same time, to check that the lowest index is served first and that extra strobes on an under-repair slot raise no second request. The bench also steps through a full window, checking the last agreement before the boundary and the one that closes it. A design that forgot the window reset, or that checked the operational limit with the wrong inequality, would leave a refurbished slot stuck. Rejected strobes with equal or out-of-range indices are shown to leave the counts untouched while `cmpErr` pulses for exactly one cycle.

// File: rtl/hst_pkg.sv
package hst_pkg;
  localparam int IDX_MAX_W = 8;

  typedef enum logic [1:0] {
    HS_PRISTINE = 2'd0,
    HS_SUSPECT  = 2'd1,
    HS_REPAIR   = 2'd2,
    HS_REFURB   = 2'd3
  } healthT;

  // strobes from control to datapath
  typedef struct packed {
    logic                 clrValid;
    logic [IDX_MAX_W-1:0] clrIdx;
  } ctlStrbT;
endpackage

// File: rtl/hst_datapath.sv
module hst_datapath
  import hst_pkg::*;
#(
  parameter int NUM_SLOTS = 20,
  parameter int WIN_LEN   = 600,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpValid,
  input  logic [IDX_W-1:0] leftIdx,
  input  logic [IDX_W-1:0] rightIdx,
  input  logic             agree,
  input  ctlStrbT          strb,
  output logic             hitVec   [NUM_SLOTS],
  output logic [CNT_W-1:0] newDisc  [NUM_SLOTS],
  output logic             winDone  [NUM_SLOTS],
  output logic [CNT_W-1:0] discCnt  [NUM_SLOTS],
  output logic [CNT_W-1:0] corrCnt  [NUM_SLOTS],
  output logic             cmpErr
);
  logic pairOk;
  logic [CNT_W-1:0] incDisc, incCorr;

  assign pairOk = cmpValid && (leftIdx != rightIdx) &&
                  (int'(leftIdx) < NUM_SLOTS) && (int'(rightIdx) < NUM_SLOTS);
  assign incDisc = {{(CNT_W-1){1'b0}}, ~agree};
  assign incCorr = {{(CNT_W-1){1'b0}}, agree};

  always_ff @(posedge clk) begin
    if (!rstN) cmpErr <= 1'b0;
    else       cmpErr <= cmpValid && !pairOk;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [IDX_W-1:0] SID = IDX_W'(s);
    logic [CNT_W-1:0] nextCorr;
    logic clrHere;

    assign hitVec[s]  = pairOk && (leftIdx == SID || rightIdx == SID);
    assign newDisc[s] = discCnt[s] + incDisc;
    assign nextCorr   = corrCnt[s] + incCorr;
    assign winDone[s] = (int'(newDisc[s]) + int'(nextCorr)) == WIN_LEN;
    assign clrHere    = strb.clrValid && (strb.clrIdx == IDX_MAX_W'(s));

    always_ff @(posedge clk) begin
      if (!rstN || clrHere) begin
        discCnt[s] <= '0;
        corrCnt[s] <= '0;
      end else if (hitVec[s]) begin
        if (winDone[s]) begin
          discCnt[s] <= '0;
          corrCnt[s] <= '0;
        end else begin
          discCnt[s] <= newDisc[s];
          corrCnt[s] <= nextCorr;
        end
      end
    end
  end
endmodule

// File: rtl/hst_control.sv
module hst_control
  import hst_pkg::*;
#(
  parameter int NUM_SLOTS = 20,
  parameter int WIN_LEN   = 600,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             agree,
  input  logic             hitVec   [NUM_SLOTS],
  input  logic [CNT_W-1:0] newDisc  [NUM_SLOTS],
  input  logic             winDone  [NUM_SLOTS],
  input  logic [CNT_W-1:0] repairMaxDisc,
  input  logic [CNT_W-1:0] operMaxDisc,
  input  logic             repAck,
  output healthT           stateVec [NUM_SLOTS],
  output logic             repReq,
  output logic [IDX_W-1:0] repSlot,
  output ctlStrbT          strb
);
  logic [NUM_SLOTS-1:0] pending;
  logic ackFire;

  // lowest-index waiting slot wins
  always_comb begin
    repSlot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pending[i]) repSlot = IDX_W'(i);
    end
  end

  assign repReq        = |pending;
  assign ackFire       = repReq && repAck;
  assign strb.clrValid = ackFire;
  assign strb.clrIdx   = IDX_MAX_W'(repSlot);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_fsm
    logic ackHere, overLimit, goodWindow;

    assign ackHere    = ackFire && (repSlot == IDX_W'(s));
    assign overLimit  = hitVec[s] && (newDisc[s] > repairMaxDisc);
    assign goodWindow = hitVec[s] && winDone[s] && (newDisc[s] <= operMaxDisc);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateVec[s] <= HS_PRISTINE;
        pending[s]  <= 1'b0;
      end else begin
        unique case (stateVec[s])
          HS_PRISTINE: if (hitVec[s] && !agree) stateVec[s] <= HS_SUSPECT;
          HS_SUSPECT: begin
            if (overLimit) begin
              stateVec[s] <= HS_REPAIR;
              pending[s]  <= 1'b1;
            end
          end
          HS_REPAIR: begin
            if (ackHere) begin
              stateVec[s] <= HS_REFURB;
              pending[s]  <= 1'b0;
            end
          end
          HS_REFURB: begin
            if (overLimit) begin
              stateVec[s] <= HS_REPAIR;
              pending[s]  <= 1'b1;
            end else if (goodWindow) begin
              stateVec[s] <= HS_PRISTINE;
            end
          end
          default: stateVec[s] <= HS_PRISTINE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hst_top.sv
module hst_top
  import hst_pkg::*;
#(
  parameter int NUM_SLOTS = 20,
  parameter int WIN_LEN   = 600,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpValid,
  input  logic [IDX_W-1:0] leftIdx,
  input  logic [IDX_W-1:0] rightIdx,
  input  logic             agree,
  input  logic [CNT_W-1:0] repairMaxDisc,
  input  logic [CNT_W-1:0] operMaxDisc,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [1:0]       rdState,
  output logic [CNT_W-1:0] rdDisc,
  output logic [CNT_W-1:0] rdCorr,
  output logic             cmpErr,
  output logic             repReq,
  output logic [IDX_W-1:0] repSlot,
  input  logic             repAck
);
  ctlStrbT          strb;
  logic             hitVec   [NUM_SLOTS];
  logic [CNT_W-1:0] newDisc  [NUM_SLOTS];
  logic             winDone  [NUM_SLOTS];
  logic [CNT_W-1:0] discCnt  [NUM_SLOTS];
  logic [CNT_W-1:0] corrCnt  [NUM_SLOTS];
  healthT           stateVec [NUM_SLOTS];
  logic             rdOk;

  hst_datapath #(.NUM_SLOTS(NUM_SLOTS), .WIN_LEN(WIN_LEN)) uDp (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .leftIdx(leftIdx),
    .rightIdx(rightIdx), .agree(agree), .strb(strb), .hitVec(hitVec),
    .newDisc(newDisc), .winDone(winDone), .discCnt(discCnt),
    .corrCnt(corrCnt), .cmpErr(cmpErr)
  );

  hst_control #(.NUM_SLOTS(NUM_SLOTS), .WIN_LEN(WIN_LEN)) uCtl (
    .clk(clk), .rstN(rstN), .agree(agree), .hitVec(hitVec),
    .newDisc(newDisc), .winDone(winDone), .repairMaxDisc(repairMaxDisc),
    .operMaxDisc(operMaxDisc), .repAck(repAck), .stateVec(stateVec),
    .repReq(repReq), .repSlot(repSlot), .strb(strb)
  );

  assign rdOk    = int'(rdIdx) < NUM_SLOTS;
  assign rdState = rdOk ? stateVec[rdIdx] : HS_PRISTINE;
  assign rdDisc  = rdOk ? discCnt[rdIdx] : '0;
  assign rdCorr  = rdOk ? corrCnt[rdIdx] : '0;
endmodule

// File: rtl/hst_checker.sv
module hst_checker #(
  parameter int NUM_SLOTS = 20,
  parameter int WIN_LEN   = 600,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(WIN_LEN + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmpValid,
  input logic [IDX_W-1:0] leftIdx,
  input logic [IDX_W-1:0] rightIdx,
  input logic [IDX_W-1:0] rdIdx,
  input logic [1:0]       rdState,
  input logic [CNT_W-1:0] rdDisc,
  input logic [CNT_W-1:0] rdCorr,
  input logic             cmpErr,
  input logic             repReq,
  input logic [IDX_W-1:0] repSlot,
  input logic             repAck
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (repReq && !repAck) |=> repReq);

  // R6
  req_slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    repReq |-> (int'(repSlot) < NUM_SLOTS));

  // R10
  same_pair_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && (leftIdx == rightIdx)) |=> cmpErr);

  // R10
  err_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid |=> !cmpErr);

  // R7
  ack_refurb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (repReq && repAck && (rdIdx == repSlot)) |=>
      ((rdState == 2'd3 && rdDisc == '0 && rdCorr == '0) || !$stable(rdIdx)));

  // R8
  window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdDisc) + int'(rdCorr)) < WIN_LEN);
endmodule

bind hst_top hst_checker #(.NUM_SLOTS(NUM_SLOTS), .WIN_LEN(WIN_LEN)) uChk (
  .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .leftIdx(leftIdx),
  .rightIdx(rightIdx), .rdIdx(rdIdx), .rdState(rdState), .rdDisc(rdDisc),
  .rdCorr(rdCorr), .cmpErr(cmpErr), .repReq(repReq), .repSlot(repSlot),
  .repAck(repAck)
);

// File: tb/tb_hst_top.sv
`timescale 1ns/1ps
module tb_hst_top;
  localparam int NUM_SLOTS = 20;
  localparam int WIN_LEN   = 600;
  localparam int IDX_W     = $clog2(NUM_SLOTS);
  localparam int CNT_W     = $clog2(WIN_LEN + 1);

  logic clk = 1'b0;
  logic rstN, cmpValid, agree, repAck;
  logic [IDX_W-1:0] leftIdx, rightIdx, rdIdx, repSlot;
  logic [CNT_W-1:0] repairMaxDisc, operMaxDisc, rdDisc, rdCorr;
  logic [1:0] rdState;
  logic cmpErr, repReq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hst_top #(.NUM_SLOTS(NUM_SLOTS), .WIN_LEN(WIN_LEN)) dut (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .leftIdx(leftIdx),
    .rightIdx(rightIdx), .agree(agree), .repairMaxDisc(repairMaxDisc),
    .operMaxDisc(operMaxDisc), .rdIdx(rdIdx), .rdState(rdState),
    .rdDisc(rdDisc), .rdCorr(rdCorr), .cmpErr(cmpErr), .repReq(repReq),
    .repSlot(repSlot), .repAck(repAck)
  );

  // stimulus table: left, right, agree, expected left state, expected right state
  localparam int NV = 7;
  localparam int VL [NV] = '{0, 0, 0, 0, 0, 0, 2};
  localparam int VR [NV] = '{1, 1, 1, 1, 1, 1, 3};
  localparam int VA [NV] = '{1, 0, 0, 0, 0, 0, 1};
  localparam int EL [NV] = '{0, 1, 1, 1, 1, 2, 0};
  localparam int ER [NV] = '{0, 1, 1, 1, 1, 2, 0};

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runCmp(input int l, input int r, input bit a, input int n);
    @(negedge clk);
    cmpValid = 1'b1; leftIdx = IDX_W'(l); rightIdx = IDX_W'(r); agree = a;
    repeat (n) @(negedge clk);
    cmpValid = 1'b0;
  endtask

  task automatic readSlot(input int idx);
    rdIdx = IDX_W'(idx);
    #0.5;
  endtask

  task automatic giveAck();
    @(negedge clk); repAck = 1'b1;
    @(negedge clk); repAck = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cmpValid = 1'b0; agree = 1'b0; repAck = 1'b0;
    leftIdx = '0; rightIdx = '0; rdIdx = '0;
    repairMaxDisc = CNT_W'(4); operMaxDisc = CNT_W'(1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < NUM_SLOTS; i++) begin
      readSlot(i);
      check("R1 state", rdState, 0);
      check("R1 disc", rdDisc, 0);
    end
    check("R1 repReq", repReq, 0);
    check("R1 cmpErr", cmpErr, 0);

    // R2 R3 R4 R5 table walk
    for (int v = 0; v < NV; v++) begin
      runCmp(VL[v], VR[v], VA[v] != 0, 1);
      readSlot(VL[v]); check("R2 R4 R5 left state", rdState, EL[v]);
      readSlot(VR[v]); check("R2 R4 R5 right state", rdState, ER[v]);
    end
    readSlot(0); check("R3 disc count", rdDisc, 5); check("R3 corr count", rdCorr, 1);
    readSlot(2); check("R3 corr count", rdCorr, 1);

    // R6 lowest index first, under-repair slot unaffected by strobes
    check("R6 repReq", repReq, 1);
    check("R6 repSlot", repSlot, 0);
    runCmp(0, 1, 1'b0, 1);
    readSlot(0); check("R6 stays under repair", rdState, 2);
    check("R6 repSlot still", repSlot, 0);

    // R7 acknowledge
    readSlot(0);
    giveAck();
    check("R7 refurbished", rdState, 3);
    check("R7 disc cleared", rdDisc, 0);
    check("R6 next slot", repSlot, 1);
    giveAck();
    readSlot(1); check("R7 second refurbished", rdState, 3);
    check("R6 single request each", repReq, 0);

    // R8 R9 window completion returns refurbished slot
    runCmp(0, 1, 1'b0, 1);
    readSlot(0); check("R9 stays refurbished", rdState, 3);
    runCmp(0, 1, 1'b1, 598);
    check("R8 corr before boundary", rdCorr, 598);
    check("R9 still refurbished", rdState, 3);
    runCmp(0, 1, 1'b1, 1);
    check("R9 back to pristine", rdState, 0);
    check("R8 disc restarted", rdDisc, 0);
    check("R8 corr restarted", rdCorr, 0);

    // R8 window on a pristine slot
    runCmp(2, 3, 1'b1, 598);
    readSlot(2); check("R8 pristine corr", rdCorr, 599);
    runCmp(2, 3, 1'b1, 1);
    check("R8 pristine restart", rdCorr, 0);
    check("R8 pristine state", rdState, 0);

    // R5 refurbished slot falls back to repair
    repairMaxDisc = '0;
    runCmp(2, 3, 1'b0, 1);
    readSlot(2); check("R4 suspect", rdState, 1);
    runCmp(2, 3, 1'b0, 1);
    check("R5 suspect to repair", rdState, 2);
    check("R6 repSlot two", repSlot, 2);
    giveAck(); giveAck();
    check("R7 slot two refurbished", rdState, 3);
    runCmp(2, 3, 1'b0, 1);
    check("R5 refurbished to repair", rdState, 2);
    check("R6 new request", repReq, 1);
    giveAck(); giveAck();
    check("R6 drained", repReq, 0);
    repairMaxDisc = CNT_W'(4);

    // R10 rejected strobes
    @(negedge clk);
    cmpValid = 1'b1; leftIdx = IDX_W'(5); rightIdx = IDX_W'(5); agree = 1'b0;
    @(negedge clk);
    cmpValid = 1'b0;
    check("R10 err same index", cmpErr, 1);
    @(negedge clk);
    check("R10 err one cycle", cmpErr, 0);
    readSlot(5); check("R10 slot five state", rdState, 0);
    check("R10 slot five disc", rdDisc, 0);
    @(negedge clk);
    cmpValid = 1'b1; leftIdx = IDX_W'(20); rightIdx = IDX_W'(1); agree = 1'b0;
    @(negedge clk);
    cmpValid = 1'b0;
    check("R10 err out of range", cmpErr, 1);
    readSlot(1); check("R10 slot one state", rdState, 0);
    check("R10 slot one disc", rdDisc, 0);
    readSlot(25); check("R2 out of range read", rdState, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule